// File: doc/BRIEF.md
# Block Floating Point Scaler

This block prepares single-precision floating-point data for a fixed-point transform and turns the transform's results back into floating point. A block of samples is streamed through twice. The first pass is the tracking pass: a tracker finds the largest biased exponent in the block and latches it as the shared block exponent when the last sample arrives. The second pass is the scaling pass, replayed from an external buffer: each sample is shifted right against that shared exponent into a 24-bit two's-complement word. The largest samples use the full range and the small ones lose low bits by truncation.

The transform returns 24-bit words together with its own signed block exponent. The rescale stage adds this exponent to the shared block exponent, normalises each word and rebuilds a single-precision value. The 24-bit datapath therefore keeps the range of a much wider one. Denormal inputs are flushed to zero. NaN and infinity are neither accepted nor produced.

Top module: `bfp_scaler`

## Requirements
- R1: After reset, `blk_exp_o` is 0 and both `fix_valid_o` and `flt_valid_o` are low.
- R2: A tracking-pass sample is one with `in_valid_i`=1 and `in_pass_i`=0. In the cycle after the sample that has `in_last_i`=1 is taken, `blk_exp_o` equals the largest exponent field (bits 30:23) among that block's tracking samples, the last one included. The next block's maximum starts again from 0.
- R3: Every scaling-pass sample (`in_valid_i`=1, `in_pass_i`=1) produces exactly one `fix_valid_o` pulse, 6 cycles later and in input order. Tracking-pass samples produce no fixed-point output.
- R4: For a sample with sign s, exponent field e (1 ≤ e ≤ `blk_exp_o`) and mantissa field m, the output is M = {1,m} >> (`blk_exp_o` − e + 1), truncated. It is given as M when s=0 and −M in 24-bit two's complement when s=1.
- R5: A sample with exponent field 0, or with a shift (`blk_exp_o` − e + 1) of 24 or more, yields 0.
- R6: A sample whose exponent field exceeds `blk_exp_o` is shifted by 1, exactly as if e equalled `blk_exp_o`.
- R7: Scaling-pass samples change neither `blk_exp_o` nor the running maximum of the next tracked block.
- R8: Every return word (`ret_valid_i`=1) produces exactly one `flt_valid_o` pulse, 6 cycles later and in order.
- R9: For a nonzero return word r with 6-bit two's-complement transform exponent t, let p be the leading-one position of |r|. If E = p + t + `blk_exp_o` − 22 lies in 1..254, the output is {sign of r, E[7:0], the 23 bits below the leading one left-aligned}.
- R10: r = 0, or E ≤ 0, yields 32'h0000_0000 (positive zero).
- R11: E ≥ 255 saturates to {sign of r, 8'hFE, 23'h7FFFFF}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Float input sample valid |
| in_pass_i | input | 1 | 0 = tracking pass, 1 = scaling pass |
| in_last_i | input | 1 | Last sample of the block (tracking pass) |
| in_data_i | input | 32 | Single-precision input sample |
| blk_exp_o | output | 8 | Shared block exponent |
| fix_valid_o | output | 1 | Fixed-point output valid |
| fix_data_o | output | 24 | Scaled two's-complement sample |
| ret_valid_i | input | 1 | Return word valid |
| ret_data_i | input | 24 | Two's-complement word from the transform |
| xfm_exp_i | input | 6 | Signed block exponent from the transform |
| flt_valid_o | output | 1 | Float output valid |
| flt_data_o | output | 32 | Rebuilt single-precision value |

## Verification
A corrupted running maximum shows up on `blk_exp_o` in the cycle after the block's last sample. Because every scaled word then carries a shift that is off by a constant, the error also appears as a systematic power-of-two error in every fixed-point output of the next pass. A pipeline stage that is dropped or duplicated breaks the exact six-cycle spacing on the first sample, and a lost valid bit shows up as an unmatched or missing result. Faults in normalisation or saturation only appear for particular leading-one positions and exponent sums, so the return stream is driven across the whole width and at both exponent extremes.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int unsigned EXP_W_D  = 8;
  localparam int unsigned MAN_W_D  = 23;
  localparam int unsigned TEXP_W_D = 6;
  localparam int unsigned SCL_LAT  = 6;
endpackage

// File: rtl/bfp_delay.sv
module bfp_delay #(
  parameter int unsigned W = 1,
  parameter int unsigned D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [D];

  for (genvar i = 0; i < D; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= d_i;
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[D-1];
endmodule

// File: rtl/bfp_max_track.sv
module bfp_max_track #(
  parameter int unsigned EXP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             last_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [EXP_W-1:0] blk_exp_o
);
  logic [EXP_W-1:0] run_q, blk_q, cand;

  assign cand = (exp_i > run_q) ? exp_i : run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      blk_q <= '0;
    end else if (vld_i) begin
      if (last_i) begin
        blk_q <= cand;
        run_q <= '0;
      end else begin
        run_q <= cand;
      end
    end
  end

  assign blk_exp_o = blk_q;

  a_r2_run_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !last_i) |=> (run_q >= $past(run_q)));
  a_r7_blk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_i && last_i) |=> $stable(blk_exp_o));
endmodule

// File: rtl/bfp_scale.sv
module bfp_scale #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned FIX_W = MAN_W + 1,
  localparam int unsigned FLT_W = EXP_W + MAN_W + 1,
  localparam int unsigned SH_W  = EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [FLT_W-1:0] data_i,
  input  logic [EXP_W-1:0] blk_exp_i,
  output logic             vld_o,
  output logic [FIX_W-1:0] fix_o
);
  logic             sgn_d;
  logic [EXP_W-1:0] exp_d, diff_d;
  logic [SH_W-1:0]  sh_d;

  assign sgn_d  = data_i[FLT_W-1];
  assign exp_d  = data_i[MAN_W +: EXP_W];
  assign diff_d = (exp_d > blk_exp_i) ? '0 : blk_exp_i - exp_d;
  assign sh_d   = {1'b0, diff_d} + SH_W'(1);

  // stage a: decode
  logic             a_vld_q, a_sgn_q, a_zero_q;
  logic [FIX_W-1:0] a_man_q;
  logic [SH_W-1:0]  a_sh_q;
  // stage b: align
  logic             b_vld_q, b_sgn_q;
  logic [FIX_W-1:0] b_mag_q;
  // stage c: sign
  logic             c_vld_q;
  logic [FIX_W-1:0] c_fix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q <= 1'b0; a_sgn_q <= 1'b0; a_zero_q <= 1'b0;
      a_man_q <= '0;   a_sh_q  <= '0;
      b_vld_q <= 1'b0; b_sgn_q <= 1'b0; b_mag_q <= '0;
      c_vld_q <= 1'b0; c_fix_q <= '0;
    end else begin
      a_vld_q  <= vld_i;
      a_sgn_q  <= sgn_d;
      a_zero_q <= (exp_d == '0);
      a_man_q  <= {1'b1, data_i[MAN_W-1:0]};
      a_sh_q   <= sh_d;
      b_vld_q  <= a_vld_q;
      b_sgn_q  <= a_sgn_q;
      b_mag_q  <= (a_zero_q || a_sh_q >= SH_W'(FIX_W)) ? '0 : a_man_q >> a_sh_q;
      c_vld_q  <= b_vld_q;
      c_fix_q  <= b_sgn_q ? -b_mag_q : b_mag_q;
    end
  end

  bfp_delay #(.W(FIX_W + 1), .D(3)) u_tail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({c_vld_q, c_fix_q}),
    .q_o   ({vld_o, fix_o})
  );

  logic [3:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + 4'(vld_i) - 4'(vld_o);

  a_r3_no_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (inflight_q != '0));
  a_r5_zero_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld_q && a_zero_q) |=> (b_mag_q == '0));
  a_r4_no_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (fix_o != {1'b1, {(FIX_W-1){1'b0}}}));
endmodule

// File: rtl/bfp_rescale.sv
module bfp_rescale #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned MAN_W  = 23,
  parameter int unsigned TEXP_W = 6,
  localparam int unsigned FIX_W = MAN_W + 1,
  localparam int unsigned FLT_W = EXP_W + MAN_W + 1,
  localparam int unsigned SUM_W = EXP_W + 4,
  localparam int unsigned P_W   = $clog2(FIX_W),
  localparam int unsigned EMAX  = (1 << EXP_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [FIX_W-1:0]  fix_i,
  input  logic [TEXP_W-1:0] texp_i,
  input  logic [EXP_W-1:0]  blk_exp_i,
  output logic              vld_o,
  output logic [FLT_W-1:0]  flt_o
);
  logic signed [SUM_W-1:0] base_d;
  assign base_d = $signed({{(SUM_W-EXP_W){1'b0}}, blk_exp_i})
                + $signed({{(SUM_W-TEXP_W){texp_i[TEXP_W-1]}}, texp_i})
                - $signed(SUM_W'(MAN_W - 1));

  // stage a: magnitude and exponent base
  logic                    a_vld_q, a_sgn_q;
  logic [FIX_W-1:0]        a_abs_q;
  logic signed [SUM_W-1:0] a_base_q;
  // stage b: leading one
  logic                    b_vld_q, b_sgn_q, b_zero_q;
  logic [FIX_W-1:0]        b_abs_q;
  logic [P_W-1:0]          b_p_q;
  logic signed [SUM_W-1:0] b_base_q;
  // stage c: normalise
  logic                    c_vld_q, c_sgn_q, c_zero_q;
  logic [MAN_W-1:0]        c_man_q;
  logic signed [SUM_W-1:0] c_exp_q;
  // stage d: pack
  logic                    d_vld_q;
  logic [FLT_W-1:0]        d_flt_q;

  logic [P_W-1:0] lead_p;
  always_comb begin
    lead_p = '0;
    for (int i = 0; i < FIX_W; i++)
      if (a_abs_q[i]) lead_p = P_W'(i);
  end

  logic [P_W-1:0] norm_sh;
  assign norm_sh = P_W'(MAN_W) - b_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_q <= 1'b0; a_sgn_q <= 1'b0; a_abs_q <= '0; a_base_q <= '0;
      b_vld_q <= 1'b0; b_sgn_q <= 1'b0; b_zero_q <= 1'b0;
      b_abs_q <= '0;   b_p_q   <= '0;   b_base_q <= '0;
      c_vld_q <= 1'b0; c_sgn_q <= 1'b0; c_zero_q <= 1'b0;
      c_man_q <= '0;   c_exp_q <= '0;
      d_vld_q <= 1'b0; d_flt_q <= '0;
    end else begin
      a_vld_q  <= vld_i;
      a_sgn_q  <= fix_i[FIX_W-1];
      a_abs_q  <= fix_i[FIX_W-1] ? -fix_i : fix_i;
      a_base_q <= base_d;
      b_vld_q  <= a_vld_q;
      b_sgn_q  <= a_sgn_q;
      b_zero_q <= (a_abs_q == '0);
      b_abs_q  <= a_abs_q;
      b_p_q    <= lead_p;
      b_base_q <= a_base_q;
      c_vld_q  <= b_vld_q;
      c_sgn_q  <= b_sgn_q;
      c_zero_q <= b_zero_q;
      c_man_q  <= MAN_W'(b_abs_q << norm_sh);
      c_exp_q  <= b_base_q + $signed({{(SUM_W-P_W){1'b0}}, b_p_q});
      d_vld_q  <= c_vld_q;
      if (c_zero_q || c_exp_q <= 0)
        d_flt_q <= '0;
      else if (c_exp_q >= $signed(SUM_W'(EMAX)))
        d_flt_q <= {c_sgn_q, EXP_W'(EMAX - 1), {MAN_W{1'b1}}};
      else
        d_flt_q <= {c_sgn_q, c_exp_q[EXP_W-1:0], c_man_q};
    end
  end

  bfp_delay #(.W(FLT_W + 1), .D(2)) u_tail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({d_vld_q, d_flt_q}),
    .q_o   ({vld_o, flt_o})
  );

  a_r10_zero_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_vld_q && c_zero_q) |=> (d_flt_q == '0));
  a_r10_pos_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && flt_o[FLT_W-2:0] == '0) |-> !flt_o[FLT_W-1]);
  a_r11_no_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (flt_o[MAN_W +: EXP_W] != '1));
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_pkg::*;
#(
  parameter int unsigned EXP_W  = EXP_W_D,
  parameter int unsigned MAN_W  = MAN_W_D,
  parameter int unsigned TEXP_W = TEXP_W_D,
  localparam int unsigned FIX_W = MAN_W + 1,
  localparam int unsigned FLT_W = EXP_W + MAN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_pass_i,
  input  logic              in_last_i,
  input  logic [FLT_W-1:0]  in_data_i,
  output logic [EXP_W-1:0]  blk_exp_o,
  output logic              fix_valid_o,
  output logic [FIX_W-1:0]  fix_data_o,
  input  logic              ret_valid_i,
  input  logic [FIX_W-1:0]  ret_data_i,
  input  logic [TEXP_W-1:0] xfm_exp_i,
  output logic              flt_valid_o,
  output logic [FLT_W-1:0]  flt_data_o
);
  logic trk_vld, scl_vld;
  assign trk_vld = in_valid_i && !in_pass_i;
  assign scl_vld = in_valid_i &&  in_pass_i;

  bfp_max_track #(.EXP_W(EXP_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (trk_vld),
    .last_i   (in_last_i),
    .exp_i    (in_data_i[MAN_W +: EXP_W]),
    .blk_exp_o(blk_exp_o)
  );

  bfp_scale #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (scl_vld),
    .data_i   (in_data_i),
    .blk_exp_i(blk_exp_o),
    .vld_o    (fix_valid_o),
    .fix_o    (fix_data_o)
  );

  bfp_rescale #(.EXP_W(EXP_W), .MAN_W(MAN_W), .TEXP_W(TEXP_W)) u_rescale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (ret_valid_i),
    .fix_i    (ret_data_i),
    .texp_i   (xfm_exp_i),
    .blk_exp_i(blk_exp_o),
    .vld_o    (flt_valid_o),
    .flt_o    (flt_data_o)
  );
endmodule

// File: tb/bfp_scaler_tb.sv
`timescale 1ns/1ps
module bfp_scaler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_pass = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [7:0]  blk_exp;
  logic        fix_valid;
  logic [23:0] fix_data;
  logic        ret_valid = 1'b0;
  logic [23:0] ret_data = '0;
  logic [5:0]  xfm_exp = '0;
  logic        flt_valid;
  logic [31:0] flt_data;

  always #2.5 clk = ~clk;

  bfp_scaler u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_pass_i(in_pass), .in_last_i(in_last), .in_data_i(in_data),
    .blk_exp_o(blk_exp), .fix_valid_o(fix_valid), .fix_data_o(fix_data),
    .ret_valid_i(ret_valid), .ret_data_i(ret_data), .xfm_exp_i(xfm_exp),
    .flt_valid_o(flt_valid), .flt_data_o(flt_data)
  );

  typedef struct { logic [31:0] v; int t; string req; } item_t;
  item_t fix_q[$];
  item_t flt_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_fix(logic [31:0] w, int emax);
    int e, sh;
    logic [23:0] mag;
    e = int'(w[30:23]);
    if (e == 0) return 24'h0;
    sh = (e > emax) ? 1 : emax - e + 1;
    if (sh >= 24) return 24'h0;
    mag = {1'b1, w[22:0]} >> sh;
    return w[31] ? -mag : mag;
  endfunction

  function automatic logic [31:0] model_flt(logic [23:0] r, logic signed [5:0] t, int emax);
    int p, ee;
    logic [23:0] a, nrm;
    logic s;
    if (r == 0) return 32'h0;
    s = r[23];
    a = s ? (~r + 24'd1) : r;
    p = 0;
    for (int i = 0; i < 24; i++) if (a[i]) p = i;
    ee = p + int'(t) + emax - 22;
    if (ee <= 0) return 32'h0;
    if (ee >= 255) return {s, 8'hFE, 23'h7FFFFF};
    nrm = a << (23 - p);
    return {s, ee[7:0], nrm[22:0]};
  endfunction

  task automatic track_block(input logic [31:0] ws[$], output int emax);
    emax = 0;
    foreach (ws[i]) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_pass = 1'b0; in_data = ws[i];
      in_last = (i == ws.size() - 1);
      if (int'(ws[i][30:23]) > emax) emax = int'(ws[i][30:23]);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check(blk_exp == 8'(emax), "R2 block max", 32'(blk_exp), 32'(emax));
  endtask

  task automatic scale_block(input logic [31:0] ws[$], input int emax);
    item_t it;
    foreach (ws[i]) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_pass = 1'b1; in_last = 1'b0; in_data = ws[i];
      it.v = 32'(model_fix(ws[i], emax));
      it.t = cyc;
      if (ws[i][30:23] == 0 || emax - int'(ws[i][30:23]) + 1 >= 24) it.req = "R3/R5";
      else if (int'(ws[i][30:23]) > emax) it.req = "R3/R6";
      else it.req = "R3/R4";
      fix_q.push_back(it);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_pass = 1'b0;
  endtask

  task automatic rescale(input logic [23:0] r, input logic [5:0] t, input int emax);
    item_t it;
    int ee;
    @(posedge clk); #1;
    ret_valid = 1'b1; ret_data = r; xfm_exp = t;
    it.v = model_flt(r, $signed(t), emax);
    it.t = cyc;
    ee = (it.v[30:23] == 8'hFE && it.v[22:0] == 23'h7FFFFF) ? 255 : 0;
    if (r == 0 || it.v == 0) it.req = "R8/R10";
    else if (ee == 255) it.req = "R8/R11";
    else it.req = "R8/R9";
    flt_q.push_back(it);
    @(posedge clk); #1;
    ret_valid = 1'b0;
  endtask

  task automatic drain();
    while (fix_q.size() != 0 || flt_q.size() != 0) @(posedge clk);
    repeat (8) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (fix_valid) begin
        if (fix_q.size() == 0) check(1'b0, "R3 unexpected fix output", 32'(fix_data), 32'h0);
        else begin
          item_t it;
          it = fix_q.pop_front();
          check(fix_data == it.v[23:0] && cyc - it.t == 6, it.req, 32'(fix_data), it.v);
        end
      end
      if (flt_valid) begin
        if (flt_q.size() == 0) check(1'b0, "R8 unexpected flt output", flt_data, 32'h0);
        else begin
          item_t it;
          it = flt_q.pop_front();
          check(flt_data == it.v && cyc - it.t == 6, it.req, flt_data, it.v);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] blk_a[$], scl_a[$], blk_b[$], rnd[$];
    logic [31:0] blk_c[$], blk_d[$];
    int em_a, em_b, em_r, em_c, em_d;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(blk_exp == 0 && !fix_valid && !flt_valid, "R1 reset state",
          {blk_exp, 22'h0, fix_valid, flt_valid}, 32'h0);

    blk_a = '{32'h3F800000, 32'hC0600000, 32'h3E800000, 32'h42C80000, 32'h00012345, 32'h2EDBE6FF};
    track_block(blk_a, em_a);
    scl_a = blk_a;
    scl_a.push_back(32'h46000000);   // exponent above block max (R6)
    scl_a.push_back(32'h80000000);   // negative zero (R5)
    scale_block(scl_a, em_a);
    drain();
    // R7: scaling pass leaves the block exponent alone
    check(blk_exp == 8'(em_a), "R7 blk_exp after scaling", 32'(blk_exp), 32'(em_a));

    // R7/R2: large scaled values must not leak into the next maximum
    blk_b = '{32'h3F000000, 32'h3F400000, 32'h3DCCCCCD};
    track_block(blk_b, em_b);
    check(em_b == 126, "R7 fresh max", 32'(em_b), 32'd126);
    scale_block(blk_b, em_b);
    rescale(24'h000000, 6'd5, em_b);
    rescale(24'h000001, 6'd0, em_b);
    rescale(24'hFFFFFF, 6'd0, em_b);
    rescale(24'h3FFFFF, 6'd3, em_b);
    rescale(24'h800000, 6'h3B, em_b);
    rescale(24'h400000, 6'd0, em_b);
    drain();

    for (int i = 0; i < 32; i++)
      rnd.push_back({1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)});
    track_block(rnd, em_r);
    scale_block(rnd, em_r);
    for (int i = 0; i < 24; i++)
      rescale(24'($urandom) >> ($urandom % 24), 6'($urandom), em_r);
    drain();

    blk_c = '{32'h7D000000};
    track_block(blk_c, em_c);
    rescale(24'h7FFFFF, 6'd31, em_c);   // R11 positive saturation
    rescale(24'h800000, 6'd20, em_c);   // R11 negative saturation
    rescale(24'hFFFFFB, 6'd10, em_c);
    drain();

    blk_d = '{32'h00800000};
    track_block(blk_d, em_d);
    scale_block(blk_d, em_d);
    rescale(24'h000001, 6'h20, em_d);   // R10 underflow
    rescale(24'hC00000, 6'h3F, em_d);   // R10 underflow of a negative value
    rescale(24'h400000, 6'd0, em_d);
    drain();

    finish_run();
  end
endmodule